// File: doc/BRIEF.md
# Dual-Select Asynchronous Byte-Wide SRAM Emulator

This block is a synthesizable functional stand-in for an asynchronous static RAM with 8192 words of 8 bits. A fast free-running clock samples the memory's pins. These are a 13-bit address, an active-low select, an active-high enable, an active-low write strobe and an active-low output enable. The tri-state data bus is split into a data input, a data output and an output-drive flag. The block is meant to sit across from a memory controller under test. It decodes each sampled pin pattern into a mode, stores bytes and returns read data. It also reports writes whose active window was shorter than the device allows.

The chip is selected only while the active-low select is low and the active-high enable is high. The write window is open while both hold and the write strobe is also low. The window closes when the first of these three signals leaves its active level. The byte stored is the data that was present on the last sample in which the window was still open. A clock-period parameter converts the 35 ns minimum window into a sample count, rounded up. A window shorter than that count sets a sticky error flag, and the byte is still stored.

Top module: `sram_emu`

## Requirements
- R1: The store holds 2^13 bytes. A byte written to one address reads back unchanged, and writing one address does not alter another.
- R2: While the select pin is high or the enable pin is low, `dout_oe` is 0 and no write takes place, whatever `wr_n` and `rd_n` are.
- R3: With select low, enable high, `wr_n` high and `rd_n` low, `dout_oe` is 1 and `dout` carries the byte at the sampled address, two clock edges after the pins settle.
- R4: With select low, enable high and `wr_n` low, `dout_oe` is 0 even when `rd_n` is low, and the byte is stored.
- R5: With the chip selected and both `wr_n` and `rd_n` high, `dout_oe` is 0 and memory is unchanged.
- R6: A write completes whichever of select (rising), enable (falling) or `wr_n` (rising) closes the window.
- R7: The stored byte is the `din` value of the last sample with the window open. A `din` change that arrives together with the closing edge is not stored.
- R8: `tim_err` is set when a window lasted fewer than ceil(35000 / CLK_PS) samples (7 at the default 5000 ps). A window of exactly that many samples does not set it.
- R9: `tim_err` stays at 1 until reset. Reset clears it to 0 and forces `dout_oe` to 0.
- R10: Reset does not alter the memory contents.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Sampling clock |
| rst_n | input | 1 | Active-low synchronous reset of control state |
| addr | input | 13 | Word address |
| din | input | 8 | Data driven toward the memory |
| dout | output | 8 | Read data |
| dout_oe | output | 1 | 1 when the memory drives the bus |
| sel_n | input | 1 | Active-low chip select |
| en | input | 1 | Active-high chip enable |
| wr_n | input | 1 | Active-low write strobe |
| rd_n | input | 1 | Active-low output enable |
| tim_err | output | 1 | Sticky short-write flag |

## Verification
The bench closes a write window with each of the three qualifying signals in turn. A design that watches only the write strobe would lose the bytes written in the select-closed and enable-closed cases. At every window end the bench flips `din`. A design that captures on the sample after the close would store the inverted byte. Windows of six and seven samples sit on either side of the length limit, so an off-by-one count shows up. A write with the output enable held low checks that the bus is not driven during a write, and a reset after stored data shows whether contents are wrongly cleared.

// File: rtl/sram_emu_pkg.sv
package sram_emu_pkg;

   typedef enum logic [1:0] {
      MODE_OFF   = 2'd0,
      MODE_HOLD  = 2'd1,
      MODE_READ  = 2'd2,
      MODE_WRITE = 2'd3
   } mode_e;

   // Select is valid only with select low and enable high
   function automatic mode_e decode_mode(input logic sel_n, input logic en,
                                         input logic wr_n, input logic rd_n);
      if (sel_n || !en) return MODE_OFF;
      else if (!wr_n)   return MODE_WRITE;
      else if (!rd_n)   return MODE_READ;
      else              return MODE_HOLD;
   endfunction

endpackage

// File: rtl/sram_emu_sync.sv
module sram_emu_sync #(
   parameter int          W      = 8,
   parameter int          STAGES = 1,
   parameter logic [W-1:0] RST   = '0
) (
   input  logic         clk,
   input  logic         rst_n,
   input  logic [W-1:0] d,
   output logic [W-1:0] q
);
   logic [W-1:0] chain [STAGES+1];
   assign chain[0] = d;

   for (genvar i = 0; i < STAGES; i++) begin : g_stage
      always_ff @(posedge clk) begin
         if (!rst_n) chain[i+1] <= RST;
         else        chain[i+1] <= chain[i];
      end
   end

   assign q = chain[STAGES];
endmodule

// File: rtl/sram_emu_ctrl.sv
module sram_emu_ctrl
   import sram_emu_pkg::*;
#(
   parameter int ADDR_W    = 13,
   parameter int DATA_W    = 8,
   parameter int CLK_PS    = 5000,
   parameter int MIN_WR_PS = 35000
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              sel_n,
   input  logic              en,
   input  logic              wr_n,
   input  logic              rd_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic              wr_stb,
   output logic [ADDR_W-1:0] wr_addr,
   output logic [DATA_W-1:0] wr_data,
   output logic              rd_oe,
   output logic              tim_err
);
   localparam int MIN_CYC = (MIN_WR_PS + CLK_PS - 1) / CLK_PS;
   localparam int CNT_W   = $clog2(MIN_CYC + 1);
   localparam logic [CNT_W-1:0] CNT_MAX = CNT_W'(MIN_CYC);

   mode_e             mode;
   logic              win, win_q;
   logic [CNT_W-1:0]  cnt;
   logic [ADDR_W-1:0] addr_q;
   logic [DATA_W-1:0] din_q;

   assign mode = decode_mode(sel_n, en, wr_n, rd_n);
   assign win  = (mode == MODE_WRITE);

   // previous sample of the window and of its address/data
   always_ff @(posedge clk) begin
      if (!rst_n) begin
         win_q  <= 1'b0;
         addr_q <= '0;
         din_q  <= '0;
      end else begin
         win_q  <= win;
         addr_q <= addr;
         din_q  <= din;
      end
   end

   // closing sample: window was open last sample, shut now
   assign wr_stb  = win_q && !win;
   assign wr_addr = addr_q;
   assign wr_data = din_q;

   always_ff @(posedge clk) begin
      if (!rst_n)                 cnt <= '0;
      else if (!win)              cnt <= '0;
      else if (cnt != CNT_MAX)    cnt <= cnt + 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n)                        tim_err <= 1'b0;
      else if (wr_stb && cnt < CNT_MAX)  tim_err <= 1'b1;
   end

   always_ff @(posedge clk) begin
      if (!rst_n) rd_oe <= 1'b0;
      else        rd_oe <= (mode == MODE_READ);
   end
endmodule

// File: rtl/sram_emu_array.sv
module sram_emu_array #(
   parameter int ADDR_W = 13,
   parameter int DATA_W = 8
) (
   input  logic              clk,
   input  logic              we,
   input  logic [ADDR_W-1:0] waddr,
   input  logic [DATA_W-1:0] wdata,
   input  logic [ADDR_W-1:0] raddr,
   output logic [DATA_W-1:0] rdata
);
   localparam int DEPTH = 1 << ADDR_W;

   logic [DATA_W-1:0] mem [DEPTH];

   // contents are not reset
   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
      rdata <= mem[raddr];
   end
endmodule

// File: rtl/sram_emu.sv
module sram_emu #(
   parameter int ADDR_W      = 13,
   parameter int DATA_W      = 8,
   parameter int CLK_PS      = 5000,
   parameter int MIN_WR_PS   = 35000,
   parameter int SYNC_STAGES = 1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic [ADDR_W-1:0] addr,
   input  logic [DATA_W-1:0] din,
   output logic [DATA_W-1:0] dout,
   output logic              dout_oe,
   input  logic              sel_n,
   input  logic              en,
   input  logic              wr_n,
   input  logic              rd_n,
   output logic              tim_err
);
   localparam int PIN_W = ADDR_W + DATA_W + 4;
   localparam logic [PIN_W-1:0] PIN_IDLE = {{(ADDR_W + DATA_W){1'b0}}, 4'b1011};

   if (CLK_PS < 1 || MIN_WR_PS < CLK_PS || SYNC_STAGES < 1 || ADDR_W < 1 || DATA_W < 1) begin : g_bad_cfg
      $error("sram_emu: illegal parameter set");
   end

   logic [PIN_W-1:0]  pins_s;
   logic [ADDR_W-1:0] smp_addr;
   logic [DATA_W-1:0] smp_din;
   logic              smp_sel_n, smp_en, smp_wr_n, smp_rd_n;
   logic              wr_stb;
   logic [ADDR_W-1:0] wr_addr;
   logic [DATA_W-1:0] wr_data;

   sram_emu_sync #(.W(PIN_W), .STAGES(SYNC_STAGES), .RST(PIN_IDLE)) u_sync (
      .clk   (clk),
      .rst_n (rst_n),
      .d     ({addr, din, sel_n, en, wr_n, rd_n}),
      .q     (pins_s)
   );

   assign {smp_addr, smp_din, smp_sel_n, smp_en, smp_wr_n, smp_rd_n} = pins_s;

   sram_emu_ctrl #(
      .ADDR_W(ADDR_W), .DATA_W(DATA_W), .CLK_PS(CLK_PS), .MIN_WR_PS(MIN_WR_PS)
   ) u_ctrl (
      .clk     (clk),
      .rst_n   (rst_n),
      .sel_n   (smp_sel_n),
      .en      (smp_en),
      .wr_n    (smp_wr_n),
      .rd_n    (smp_rd_n),
      .addr    (smp_addr),
      .din     (smp_din),
      .wr_stb  (wr_stb),
      .wr_addr (wr_addr),
      .wr_data (wr_data),
      .rd_oe   (dout_oe),
      .tim_err (tim_err)
   );

   sram_emu_array #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_array (
      .clk   (clk),
      .we    (wr_stb),
      .waddr (wr_addr),
      .wdata (wr_data),
      .raddr (smp_addr),
      .rdata (dout)
   );
endmodule

// File: rtl/sram_emu_chk.sv
module sram_emu_chk (
   input logic clk,
   input logic rst_n,
   input logic s_sel_n,
   input logic s_en,
   input logic s_wr_n,
   input logic s_rd_n,
   input logic wr_stb,
   input logic dout_oe,
   input logic tim_err
);
   logic s_win;
   assign s_win = !s_sel_n && s_en && !s_wr_n;

   p_desel_hiz_r2: assert property (@(posedge clk) disable iff (!rst_n)
      (s_sel_n || !s_en) |=> !dout_oe);

   p_read_drive_r3: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_sel_n && s_en && s_wr_n && !s_rd_n) |=> dout_oe);

   p_write_hiz_r4: assert property (@(posedge clk) disable iff (!rst_n)
      s_win |=> !dout_oe);

   p_hold_hiz_r5: assert property (@(posedge clk) disable iff (!rst_n)
      (!s_sel_n && s_en && s_wr_n && s_rd_n) |=> !dout_oe);

   p_commit_close_r6: assert property (@(posedge clk) disable iff (!rst_n)
      wr_stb |-> (!s_win && $past(s_win)));

   p_err_cause_r8: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(tim_err) |-> $past(wr_stb));

   p_err_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
      tim_err |=> tim_err);
endmodule

bind sram_emu sram_emu_chk u_chk (
   .clk     (clk),
   .rst_n   (rst_n),
   .s_sel_n (smp_sel_n),
   .s_en    (smp_en),
   .s_wr_n  (smp_wr_n),
   .s_rd_n  (smp_rd_n),
   .wr_stb  (wr_stb),
   .dout_oe (dout_oe),
   .tim_err (tim_err)
);

// File: tb/sram_emu_test.sv
`timescale 1ns/1ps
module sram_emu_test;
   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic [12:0] addr = '0;
   logic [7:0]  din = '0;
   logic [7:0]  dout;
   logic        dout_oe;
   logic        sel_n = 1'b1, en = 1'b0, wr_n = 1'b1, rd_n = 1'b1;
   logic        tim_err;

   int n_chk = 0;
   int n_err = 0;
   int cyc = 0;

   always #2.5 clk = ~clk;

   sram_emu uut (
      .clk(clk), .rst_n(rst_n), .addr(addr), .din(din), .dout(dout),
      .dout_oe(dout_oe), .sel_n(sel_n), .en(en), .wr_n(wr_n), .rd_n(rd_n),
      .tim_err(tim_err)
   );

   // {sel_n, en, wr_n, rd_n, expected dout_oe}; no entry opens a write window
   localparam logic [4:0] VEC [8] = '{
      5'b10100, 5'b11100, 5'b00100, 5'b10000,
      5'b11000, 5'b00000, 5'b01101, 5'b01110
   };

   task automatic chk(string req, logic [31:0] act, logic [31:0] exp, string what);
      n_chk++;
      if (act !== exp) begin
         n_err++;
         $display("FAIL %s %s: actual=%0h expected=%0h", req, what, act, exp);
      end
   endtask

   task automatic idle();
      sel_n = 1'b1; en = 1'b0; wr_n = 1'b1; rd_n = 1'b1;
   endtask

   // term: 0 = wr_n rises, 1 = select rises, 2 = enable falls
   task automatic do_write(logic [12:0] a, logic [7:0] d, int len, int term, logic oe_low);
      @(negedge clk);
      addr = a; din = d; sel_n = 1'b0; en = 1'b1; wr_n = 1'b0; rd_n = !oe_low;
      repeat (len) @(negedge clk);
      case (term)
         0: wr_n = 1'b1;
         1: sel_n = 1'b1;
         default: en = 1'b0;
      endcase
      din = ~d;
      repeat (2) @(negedge clk);
      idle();
      repeat (2) @(negedge clk);
   endtask

   task automatic do_read(logic [12:0] a, logic [7:0] exp, string req);
      @(negedge clk);
      addr = a; sel_n = 1'b0; en = 1'b1; wr_n = 1'b1; rd_n = 1'b0;
      repeat (3) @(negedge clk);
      chk(req, 32'(dout_oe), 32'd1, "read drive");
      chk(req, 32'(dout), 32'(exp), "read data");
      idle();
   endtask

   always @(posedge clk) begin
      cyc++;
      if (cyc > 20000) begin
         n_err++;
         $display("FAIL watchdog: actual=%0d expected<=20000 cycles", cyc);
         $display("Result: errors=%0d of %0d checks", n_err, n_chk);
         $finish;
      end
   end

   initial begin
      repeat (4) @(negedge clk);
      chk("R9", 32'(dout_oe), 32'd0, "oe in reset");
      chk("R9", 32'(tim_err), 32'd0, "err in reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R1: several addresses incl. both ends, each closed by wr_n (R6)
      do_write(13'h0155, 8'hA5, 7, 0, 1'b0);
      do_write(13'h0000, 8'h3C, 8, 0, 1'b0);
      do_write(13'h1FFF, 8'hC3, 9, 0, 1'b0);
      do_read(13'h0155, 8'hA5, "R1");
      do_read(13'h0000, 8'h3C, "R1");
      do_read(13'h1FFF, 8'hC3, "R1");
      chk("R8", 32'(tim_err), 32'd0, "no err at exactly min window");

      // vector table: R2 deselect, R3 read, R5 hold
      addr = 13'h0155;
      foreach (VEC[i]) begin
         @(negedge clk);
         {sel_n, en, wr_n, rd_n} = VEC[i][4:1];
         repeat (3) @(negedge clk);
         chk(VEC[i][0] ? "R3" : "R2/R5", 32'(dout_oe), 32'(VEC[i][0]), $sformatf("vector %0d oe", i));
         if (VEC[i][0]) chk("R3", 32'(dout), 32'hA5, "vector read data");
      end
      idle();
      do_read(13'h0155, 8'hA5, "R5");

      // R6: close by select and by enable; R7 din flip at close ignored
      do_write(13'h0AAA, 8'h5A, 8, 1, 1'b0);
      do_write(13'h0555, 8'h96, 8, 2, 1'b0);
      do_read(13'h0AAA, 8'h5A, "R6");
      do_read(13'h0555, 8'h96, "R7");

      // R4: output enable low during write; check bus not driven mid-window
      @(negedge clk);
      addr = 13'h0123; din = 8'h71; sel_n = 1'b0; en = 1'b1; wr_n = 1'b0; rd_n = 1'b0;
      repeat (4) @(negedge clk);
      chk("R4", 32'(dout_oe), 32'd0, "no drive during write");
      repeat (4) @(negedge clk);
      wr_n = 1'b1; rd_n = 1'b1;
      repeat (2) @(negedge clk);
      idle();
      do_read(13'h0123, 8'h71, "R4");
      chk("R8", 32'(tim_err), 32'd0, "no err after long writes");

      // R8: six-sample window is short; byte still stored
      do_write(13'h0042, 8'hE7, 6, 0, 1'b0);
      chk("R8", 32'(tim_err), 32'd1, "short window flagged");
      do_read(13'h0042, 8'hE7, "R8");

      // R9: sticky across a good write, cleared by reset
      do_write(13'h0043, 8'h18, 10, 0, 1'b0);
      chk("R9", 32'(tim_err), 32'd1, "err sticky");
      @(negedge clk); rst_n = 1'b0;
      repeat (2) @(negedge clk);
      chk("R9", 32'(tim_err), 32'd0, "err cleared by reset");
      rst_n = 1'b1;
      repeat (2) @(negedge clk);

      // R10: contents survive reset
      do_read(13'h0155, 8'hA5, "R10");
      do_read(13'h0043, 8'h18, "R10");

      $display("Result: errors=%0d of %0d checks", n_err, n_chk);
      $finish;
   end
endmodule